// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block produces the word a parallel NOR flash returns on its data pins while an embedded program, erase or blank check is running. A controller state machine starts an operation by pulsing `op_start` with an operation code. It supplies the most significant bit of the byte being written and the block the operation targets, and reports completion, failure and buffer aborts. The erase engine supplies a mask of the blocks it is erasing and a flag that the erase-command window has closed.

On every read the block decides whether the addressed block sees status or plain array contents. It then composes an 8-bit word from these parts:

- the data-polling bit (bit 7)
- two toggle bits (bits 6 and 2)
- the failure bit (bit 5)
- the erase-window bit (bit 3)
- the abort bit (bit 1)

The two toggle bits are flip-flops that invert on each status read. A ready/busy pin is driven low while an operation is actually busy and is released otherwise; `ry_by_oe_o` low stands for the high-impedance state. After a failure or an abort the block locks, and only a READ/RESET command frees it.

Top module: `flash_status_reporter`

## Requirements
- R1: After reset the block is in read mode, `dq_o` equals `array_data`, `ry_by_oe_o` is 0 and both toggle flops are 0.
- R2: With program active (code 1), `dq_o` = {~polled bit, T, 6'b0}, where T is the bit-6 toggle flop. `ry_by_oe_o`=1 and `ry_by_o`=0 for every busy code (1 to 5) when no failure or abort is latched.
- R3: With buffered program (code 2), the polled bit is the `buf_poll` value of the most recent `buf_load`, which replaces the value captured at `op_start`.
- R4: With chip erase (code 4), `dq_o` = {0, T, 0, 0, 1, T, 0, 0} for every block.
- R5: With block erase (code 3), bit 6 toggles, bit 3 follows `erase_tmo`, and bit 2 toggles only when `erase_mask[rd_block]`=1 (0 otherwise). All other bits are 0.
- R6: With erase suspend (code 7), a read of an erasing block returns {1, 0, 0, 0, 0, T, 0, 0}, a read of any other block returns `array_data`, and `ry_by_oe_o`=0.
- R7: With program suspend (code 6), a read of the block captured by the last non-suspend `op_start` returns 8'h00, other blocks return `array_data`, and `ry_by_oe_o`=0.
- R8: `fail_in` during a busy code latches a failure. Bit 5 then reads 1 on top of that code's word, bit 6 keeps toggling, and `ry_by_oe_o`=0. `fail_in` in read mode has no effect.
- R9: While a failure or abort is latched, `op_start`, `buf_load` and `op_done` are ignored. `reset_cmd` clears the latches and returns the block to read mode.
- R10: `abort_in` during buffered program sets bit 1 while bit 7 keeps the inverted polled bit and bit 6 keeps toggling; `ry_by_oe_o`=0.
- R11: The toggle flops invert only on cycles where `rd_stb`=1 and the word returned is a status word, so back-to-back status reads differ in bit 6. Reads of array contents and idle cycles leave them unchanged.
- R12: `op_done` returns the block to read mode, where `dq_o` = `array_data` and `ry_by_oe_o`=0.
- R13: With blank check (code 5), `dq_o` = {0, T, F, 5'b0}, where F is the failure latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Load a new operation code |
| op_code | input | 3 | 0 read, 1 program, 2 buffered program, 3 block erase, 4 chip erase, 5 blank check, 6 program suspend, 7 erase suspend |
| op_poll | input | 1 | Bit 7 of the byte being programmed, captured on a non-suspend start |
| op_block | input | BLK_W | Target block, captured on a non-suspend start |
| buf_load | input | 1 | A buffer word was loaded |
| buf_poll | input | 1 | Bit 7 of that buffer word |
| fail_in | input | 1 | Embedded operation failed |
| abort_in | input | 1 | Buffered program aborted |
| op_done | input | 1 | Operation completed successfully |
| reset_cmd | input | 1 | READ/RESET command |
| erase_tmo | input | 1 | Erase-command window expired |
| erase_mask | input | NUM_BLOCKS | One bit per block being erased |
| rd_stb | input | 1 | A read is performed this cycle |
| rd_block | input | BLK_W | Block addressed by the read |
| array_data | input | 8 | Array contents at the read address |
| dq_o | output | 8 | Read data or status word |
| ry_by_o | output | 1 | Ready/busy level when driven |
| ry_by_oe_o | output | 1 | Ready/busy drive enable; 0 means high-Z |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before use, and that `rd_block` addresses an existing block. They also assume the controller does not pulse `op_start` in the same cycle as a status read whose toggle history is being checked. The stimulus table keeps to this: control pulses and reads sit in separate rows, and every block number in the table lies below `NUM_BLOCKS`. The reset-to-read and toggle-reset cases are driven as directed steps after the table, because they need `rst_n` itself.

// File: rtl/flash_status_pkg.sv
// Package: operation codes and status-word bit positions shared by the
// status reporter and its checker. Assumes an 8-bit data bus.
package flash_status_pkg;

    localparam int STAT_W   = 8;
    localparam int POS_POLL = 7;
    localparam int POS_TOGA = 6;
    localparam int POS_FAIL = 5;
    localparam int POS_TMR  = 3;
    localparam int POS_TOGB = 2;
    localparam int POS_ABRT = 1;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_PROG      = 3'd1,
        OP_BUFPROG   = 3'd2,
        OP_BLKERASE  = 3'd3,
        OP_CHIPERASE = 3'd4,
        OP_BLANKCHK  = 3'd5,
        OP_PSUSP     = 3'd6,
        OP_ESUSP     = 3'd7
    } op_e;

    // True for codes that keep the embedded engine busy.
    function automatic logic op_is_busy(op_e op);
        return (op == OP_PROG) || (op == OP_BUFPROG) || (op == OP_BLKERASE) ||
               (op == OP_CHIPERASE) || (op == OP_BLANKCHK);
    endfunction

    // True for the two suspend codes.
    function automatic logic op_is_susp(op_e op);
        return (op == OP_PSUSP) || (op == OP_ESUSP);
    endfunction

endpackage

// File: rtl/flash_op_tracker.sv
// Tracks the current operation, the polled data bit, the target block and
// the failure/abort latches. Assumes strobes are one cycle wide and that the
// controller issues suspend codes only over a running operation.
module flash_op_tracker
    import flash_status_pkg::*;
#(
    parameter int BLK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic [2:0]       op_code,
    input  logic             op_poll,
    input  logic [BLK_W-1:0] op_block,
    input  logic             buf_load,
    input  logic             buf_poll,
    input  logic             fail_in,
    input  logic             abort_in,
    input  logic             op_done,
    input  logic             reset_cmd,
    output op_e              cur_op,
    output logic             poll_bit,
    output logic [BLK_W-1:0] tgt_block,
    output logic             fail_q,
    output logic             abort_q,
    output logic             locked
);

    op_e op_q;
    op_e op_req;

    assign op_req = op_e'(op_code);
    assign locked = fail_q | abort_q;

    // Operation register: start, completion and READ/RESET handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_READ;
        end else if (reset_cmd) begin
            op_q <= OP_READ;
        end else if (!locked) begin
            if (op_start) begin
                op_q <= op_req;
            end else if (op_done) begin
                op_q <= OP_READ;
            end
        end
    end

    // Captured polled bit and target block; buffer loads refresh the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_bit  <= 1'b0;
            tgt_block <= '0;
        end else if (!locked && !reset_cmd) begin
            if (op_start && !op_is_susp(op_req)) begin
                poll_bit  <= op_poll;
                tgt_block <= op_block;
            end else if (buf_load && !op_start && (op_q == OP_BUFPROG)) begin
                poll_bit <= buf_poll;
            end
        end
    end

    // Failure and abort latches, cleared only by READ/RESET.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q  <= 1'b0;
            abort_q <= 1'b0;
        end else if (reset_cmd) begin
            fail_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            if (fail_in && op_is_busy(op_q)) begin
                fail_q <= 1'b1;
            end
            if (abort_in && (op_q == OP_BUFPROG)) begin
                abort_q <= 1'b1;
            end
        end
    end

    assign cur_op = op_q;

endmodule

// File: rtl/flash_toggle_bank.sv
// Bank of toggle flip-flops. Each flop inverts on a clock edge where a read
// strobe returns a status word. Assumes the strobe is synchronous to clk.
module flash_toggle_bank #(
    parameter int NUM_TOG = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_stb,
    input  logic               status_rd,
    output logic [NUM_TOG-1:0] tog_o
);

    logic flip_en;
    assign flip_en = rd_stb & status_rd;

    for (genvar i = 0; i < NUM_TOG; i++) begin : g_tog
        logic bit_q;

        // One toggle flop, inverted per status read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (flip_en) begin
                bit_q <= ~bit_q;
            end
        end

        assign tog_o[i] = bit_q;
    end

endmodule

// File: rtl/flash_status_mux.sv
// Composes the read word from the current operation, the addressed block and
// the latches, and drives the ready/busy pin model. Purely combinational.
// Assumes rd_block is below NUM_BLOCKS; out-of-range reads count as non-erasing.
module flash_status_mux
    import flash_status_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_W      = 3
) (
    input  op_e                   cur_op,
    input  logic                  poll_bit,
    input  logic [BLK_W-1:0]      tgt_block,
    input  logic                  fail_q,
    input  logic                  abort_q,
    input  logic                  locked,
    input  logic                  erase_tmo,
    input  logic [NUM_BLOCKS-1:0] erase_mask,
    input  logic [BLK_W-1:0]      rd_block,
    input  logic [STAT_W-1:0]     array_data,
    input  logic [1:0]            tog,
    output logic [STAT_W-1:0]     dq,
    output logic                  status_rd,
    output logic                  ry_by,
    output logic                  ry_by_oe
);

    logic blk_erasing;
    logic blk_target;
    logic busy;
    logic tog_a;
    logic tog_b;

    assign tog_a = tog[0];
    assign tog_b = tog[1];

    // Erase-mask lookup for the addressed block.
    always_comb begin
        blk_erasing = 1'b0;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (rd_block == BLK_W'(b)) begin
                blk_erasing = erase_mask[b];
            end
        end
    end

    assign blk_target = (rd_block == tgt_block);

    // Status word selection per operation and addressed block.
    always_comb begin
        dq        = '0;
        status_rd = 1'b1;
        unique case (cur_op)
            OP_READ: begin
                dq        = array_data;
                status_rd = 1'b0;
            end
            OP_PROG: begin
                dq[POS_POLL] = ~poll_bit;
                dq[POS_TOGA] = tog_a;
                dq[POS_FAIL] = fail_q;
            end
            OP_BUFPROG: begin
                dq[POS_POLL] = ~poll_bit;
                dq[POS_TOGA] = tog_a;
                dq[POS_FAIL] = fail_q;
                dq[POS_ABRT] = abort_q;
            end
            OP_BLKERASE: begin
                dq[POS_TOGA] = tog_a;
                dq[POS_FAIL] = fail_q;
                dq[POS_TMR]  = erase_tmo;
                dq[POS_TOGB] = blk_erasing & tog_b;
            end
            OP_CHIPERASE: begin
                dq[POS_TOGA] = tog_a;
                dq[POS_FAIL] = fail_q;
                dq[POS_TMR]  = 1'b1;
                dq[POS_TOGB] = tog_b;
            end
            OP_BLANKCHK: begin
                dq[POS_TOGA] = tog_a;
                dq[POS_FAIL] = fail_q;
            end
            OP_PSUSP: begin
                if (!blk_target) begin
                    dq        = array_data;
                    status_rd = 1'b0;
                end
            end
            OP_ESUSP: begin
                if (blk_erasing) begin
                    dq[POS_POLL] = 1'b1;
                    dq[POS_TOGB] = tog_b;
                end else begin
                    dq        = array_data;
                    status_rd = 1'b0;
                end
            end
            default: begin
                dq        = array_data;
                status_rd = 1'b0;
            end
        endcase
    end

    // Ready/busy: driven low only while busy and not halted by a latch.
    assign busy     = op_is_busy(cur_op) & ~locked;
    assign ry_by_oe = busy;
    assign ry_by    = ~busy;

endmodule

// File: rtl/flash_status_reporter.sv
// Top level of the status reporter: operation tracker, toggle flops and the
// read-word multiplexer. Assumes a synchronous active-low reset and inputs
// synchronous to clk.
module flash_status_reporter
    import flash_status_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_start,
    input  logic [2:0]            op_code,
    input  logic                  op_poll,
    input  logic [BLK_W-1:0]      op_block,
    input  logic                  buf_load,
    input  logic                  buf_poll,
    input  logic                  fail_in,
    input  logic                  abort_in,
    input  logic                  op_done,
    input  logic                  reset_cmd,
    input  logic                  erase_tmo,
    input  logic [NUM_BLOCKS-1:0] erase_mask,
    input  logic                  rd_stb,
    input  logic [BLK_W-1:0]      rd_block,
    input  logic [7:0]            array_data,
    output logic [7:0]            dq_o,
    output logic                  ry_by_o,
    output logic                  ry_by_oe_o
);

    localparam int NUM_TOG = 2;

    op_e              cur_op;
    logic             poll_bit;
    logic [BLK_W-1:0] tgt_block;
    logic             fail_q;
    logic             abort_q;
    logic             locked;
    logic             status_rd;
    logic [NUM_TOG-1:0] tog;

    flash_op_tracker #(
        .BLK_W (BLK_W)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_start  (op_start),
        .op_code   (op_code),
        .op_poll   (op_poll),
        .op_block  (op_block),
        .buf_load  (buf_load),
        .buf_poll  (buf_poll),
        .fail_in   (fail_in),
        .abort_in  (abort_in),
        .op_done   (op_done),
        .reset_cmd (reset_cmd),
        .cur_op    (cur_op),
        .poll_bit  (poll_bit),
        .tgt_block (tgt_block),
        .fail_q    (fail_q),
        .abort_q   (abort_q),
        .locked    (locked)
    );

    flash_toggle_bank #(
        .NUM_TOG (NUM_TOG)
    ) u_toggle (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .status_rd (status_rd),
        .tog_o     (tog)
    );

    flash_status_mux #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_mux (
        .cur_op     (cur_op),
        .poll_bit   (poll_bit),
        .tgt_block  (tgt_block),
        .fail_q     (fail_q),
        .abort_q    (abort_q),
        .locked     (locked),
        .erase_tmo  (erase_tmo),
        .erase_mask (erase_mask),
        .rd_block   (rd_block),
        .array_data (array_data),
        .tog        (tog),
        .dq         (dq_o),
        .status_rd  (status_rd),
        .ry_by      (ry_by_o),
        .ry_by_oe   (ry_by_oe_o)
    );

endmodule

// File: rtl/flash_status_reporter_sva.sv
// Checker for the status reporter, attached by bind. Watches the ports and
// the tracker state that the multiplexer consumes.
module flash_status_reporter_sva
    import flash_status_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       reset_cmd,
    input logic [7:0] array_data,
    input logic [7:0] dq_o,
    input logic       ry_by_o,
    input logic       ry_by_oe_o,
    input op_e        cur_op,
    input logic       fail_q,
    input logic       locked
);

    AST_TOG_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && ry_by_oe_o) ##1 (rd_stb && ry_by_oe_o) |-> (dq_o[6] != $past(dq_o[6]))); // R11

    AST_BUSY_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_is_busy(cur_op) && !locked) |-> (ry_by_oe_o && !ry_by_o)); // R2

    AST_SUSP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_susp(cur_op) |-> !ry_by_oe_o); // R6

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !reset_cmd) |=> fail_q); // R9

    AST_LOCK_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !reset_cmd) |=> $stable(cur_op)); // R9

    AST_FAIL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && op_is_busy(cur_op)) |-> dq_o[5]); // R8

    AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == OP_READ) |-> (dq_o == array_data)); // R12

    AST_CHIP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == OP_CHIPERASE) |-> (!dq_o[7] && dq_o[3])); // R4

endmodule

bind flash_status_reporter flash_status_reporter_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .reset_cmd  (reset_cmd),
    .array_data (array_data),
    .dq_o       (dq_o),
    .ry_by_o    (ry_by_o),
    .ry_by_oe_o (ry_by_oe_o),
    .cur_op     (cur_op),
    .fail_q     (fail_q),
    .locked     (locked)
);

// File: tb/flash_status_reporter_tb.sv
// Bench: walks a vector table of strobes and reads, then directed reset cases.
module flash_status_reporter_tb;

    localparam int NB = 8;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0;
    logic [2:0]    op_code = '0;
    logic          op_poll = 1'b0;
    logic [BW-1:0] op_block = '0;
    logic          buf_load = 1'b0;
    logic          buf_poll = 1'b0;
    logic          fail_in = 1'b0;
    logic          abort_in = 1'b0;
    logic          op_done = 1'b0;
    logic          reset_cmd = 1'b0;
    logic          erase_tmo = 1'b0;
    logic [NB-1:0] erase_mask = 8'b0000_0110;
    logic          rd_stb = 1'b0;
    logic [BW-1:0] rd_block = '0;
    logic [7:0]    array_data;
    logic [7:0]    dq_o;
    logic          ry_by_o;
    logic          ry_by_oe_o;

    int  total = 0;
    int  bad = 0;
    logic tg = 1'b0;
    logic finished = 1'b0;

    assign array_data = {5'b10100, rd_block};

    always #5 clk = ~clk;

    flash_status_reporter #(.NUM_BLOCKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
        .op_poll(op_poll), .op_block(op_block), .buf_load(buf_load),
        .buf_poll(buf_poll), .fail_in(fail_in), .abort_in(abort_in),
        .op_done(op_done), .reset_cmd(reset_cmd), .erase_tmo(erase_tmo),
        .erase_mask(erase_mask), .rd_stb(rd_stb), .rd_block(rd_block),
        .array_data(array_data), .dq_o(dq_o), .ry_by_o(ry_by_o),
        .ry_by_oe_o(ry_by_oe_o)
    );

    typedef struct packed {
        logic       chk;
        logic [3:0] req;
        logic       start;
        logic [2:0] code;
        logic       d7;
        logic       ld;
        logic       fail;
        logic       abrt;
        logic       done;
        logic       rcmd;
        logic       tmo;
        logic       rd;
        logic [2:0] blk;
        logic       arr;
        logic [7:0] exp;
        logic       f6;
        logic       f2;
        logic       oe;
    } vec_t;

    localparam int NV = 52;
    // Fields: chk req start code d7 ld fail abrt done rcmd tmo rd blk arr exp f6 f2 oe
    localparam vec_t VEC [NV] = '{
        '{1,4'd1, 0,3'd0,0,0,0,0,0,0,0,0,3'd3,1,8'h00,0,0,0}, // R1 read mode
        '{0,4'd2, 1,3'd1,0,0,0,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // start program, bit7=0
        '{1,4'd2, 0,3'd0,0,0,0,0,0,0,0,1,3'd4,0,8'h80,1,0,1}, // R2
        '{1,4'd2, 0,3'd0,0,0,0,0,0,0,0,1,3'd4,0,8'h80,1,0,1}, // R2 toggled
        '{1,4'd11,0,3'd0,0,0,0,0,0,0,0,0,3'd4,0,8'h80,1,0,1}, // R11 no read no flip
        '{0,4'd12,0,3'd0,0,0,0,0,1,0,0,0,3'd0,0,8'h00,0,0,0}, // done
        '{1,4'd12,0,3'd0,0,0,0,0,0,0,0,1,3'd5,1,8'h00,0,0,0}, // R12 array
        '{0,4'd3, 1,3'd2,0,0,0,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // start buffered
        '{0,4'd3, 0,3'd0,1,1,0,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // load bit7=1
        '{1,4'd3, 0,3'd0,0,0,0,0,0,0,0,1,3'd0,0,8'h00,1,0,1}, // R3
        '{0,4'd10,0,3'd0,0,0,0,1,0,0,0,0,3'd0,0,8'h00,0,0,0}, // abort
        '{1,4'd10,0,3'd0,0,0,0,0,0,0,0,1,3'd0,0,8'h02,1,0,0}, // R10
        '{0,4'd9, 1,3'd1,0,1,0,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // ignored start+load
        '{1,4'd9, 0,3'd0,0,0,0,0,0,0,0,1,3'd0,0,8'h02,1,0,0}, // R9 still locked
        '{0,4'd9, 0,3'd0,0,0,0,0,0,1,0,0,3'd0,0,8'h00,0,0,0}, // READ/RESET
        '{1,4'd9, 0,3'd0,0,0,0,0,0,0,0,1,3'd6,1,8'h00,0,0,0}, // R9 back in read
        '{0,4'd4, 1,3'd4,0,0,0,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // chip erase
        '{1,4'd4, 0,3'd0,0,0,0,0,0,0,0,1,3'd0,0,8'h08,1,1,1}, // R4
        '{1,4'd4, 0,3'd0,0,0,0,0,0,0,0,1,3'd7,0,8'h08,1,1,1}, // R4
        '{0,4'd8, 0,3'd0,0,0,1,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // fail
        '{1,4'd8, 0,3'd0,0,0,0,0,0,0,0,1,3'd0,0,8'h28,1,1,0}, // R8
        '{0,4'd12,0,3'd0,0,0,0,0,1,0,0,0,3'd0,0,8'h00,0,0,0}, // done ignored
        '{1,4'd12,0,3'd0,0,0,0,0,0,0,0,1,3'd0,0,8'h28,1,1,0}, // R12 locked holds
        '{0,4'd9, 0,3'd0,0,0,0,0,0,1,0,0,3'd0,0,8'h00,0,0,0}, // READ/RESET
        '{0,4'd5, 1,3'd3,0,0,0,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // block erase
        '{1,4'd5, 0,3'd0,0,0,0,0,0,0,0,1,3'd1,0,8'h00,1,1,1}, // R5 erasing, window open
        '{1,4'd5, 0,3'd0,0,0,0,0,0,0,1,1,3'd5,0,8'h08,1,0,1}, // R5 non-erasing
        '{1,4'd5, 0,3'd0,0,0,0,0,0,0,1,1,3'd2,0,8'h08,1,1,1}, // R5 erasing
        '{0,4'd6, 1,3'd7,0,0,0,0,0,0,1,0,3'd0,0,8'h00,0,0,0}, // erase suspend
        '{1,4'd6, 0,3'd0,0,0,0,0,0,0,1,1,3'd1,0,8'h80,0,1,0}, // R6 erasing block
        '{1,4'd6, 0,3'd0,0,0,0,0,0,0,1,1,3'd1,0,8'h80,0,1,0}, // R6 toggled
        '{1,4'd6, 0,3'd0,0,0,0,0,0,0,1,1,3'd4,1,8'h00,0,0,0}, // R6 array
        '{0,4'd5, 1,3'd3,0,0,0,0,0,0,1,0,3'd0,0,8'h00,0,0,0}, // resume
        '{0,4'd12,0,3'd0,0,0,0,0,1,0,0,0,3'd0,0,8'h00,0,0,0}, // done
        '{0,4'd13,1,3'd5,0,0,0,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // blank check
        '{1,4'd13,0,3'd0,0,0,0,0,0,0,0,1,3'd0,0,8'h00,1,0,1}, // R13
        '{0,4'd8, 0,3'd0,0,0,1,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // fail
        '{1,4'd13,0,3'd0,0,0,0,0,0,0,0,1,3'd0,0,8'h20,1,0,0}, // R13 with failure
        '{0,4'd9, 0,3'd0,0,0,0,0,0,1,0,0,3'd0,0,8'h00,0,0,0}, // READ/RESET
        '{0,4'd2, 1,3'd1,1,0,0,0,0,0,0,0,3'd3,0,8'h00,0,0,0}, // program blk3 bit7=1
        '{1,4'd2, 0,3'd0,0,0,0,0,0,0,0,1,3'd0,0,8'h00,1,0,1}, // R2
        '{0,4'd7, 1,3'd6,0,0,0,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // program suspend
        '{1,4'd7, 0,3'd0,0,0,0,0,0,0,0,1,3'd3,0,8'h00,0,0,0}, // R7 target block
        '{1,4'd7, 0,3'd0,0,0,0,0,0,0,0,1,3'd0,1,8'h00,0,0,0}, // R7 other block
        '{0,4'd2, 1,3'd1,1,0,0,0,0,0,0,0,3'd3,0,8'h00,0,0,0}, // resume
        '{1,4'd2, 0,3'd0,0,0,0,0,0,0,0,1,3'd3,0,8'h00,1,0,1}, // R2
        '{0,4'd12,0,3'd0,0,0,0,0,1,0,0,0,3'd0,0,8'h00,0,0,0}, // done
        '{1,4'd12,0,3'd0,0,0,0,0,0,0,0,1,3'd5,1,8'h00,0,0,0}, // R12
        '{0,4'd8, 0,3'd0,0,0,1,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // fail in read mode
        '{0,4'd8, 1,3'd1,0,0,0,0,0,0,0,0,3'd0,0,8'h00,0,0,0}, // program bit7=0
        '{1,4'd8, 0,3'd0,0,0,0,0,0,0,0,1,3'd0,0,8'h80,1,0,1}, // R8 no stale failure
        '{0,4'd12,0,3'd0,0,0,0,0,1,0,0,0,3'd0,0,8'h00,0,0,0}  // done
    };

    task automatic check_val(input int req, input string what,
                             input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        op_start  = v.start;
        op_code   = v.code;
        op_poll   = v.d7;
        op_block  = v.blk;
        buf_load  = v.ld;
        buf_poll  = v.d7;
        fail_in   = v.fail;
        abort_in  = v.abrt;
        op_done   = v.done;
        reset_cmd = v.rcmd;
        erase_tmo = v.tmo;
        rd_stb    = v.rd;
        rd_block  = v.blk;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tg = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #1;
            if (VEC[i].chk) begin
                e = VEC[i].arr ? array_data
                    : (VEC[i].exp | ({7'b0, VEC[i].f6 & tg} << 6) | ({7'b0, VEC[i].f2 & tg} << 2));
                check_val(int'(VEC[i].req), "dq", dq_o, e);
                check_val(int'(VEC[i].req), "ry_oe", {7'b0, ry_by_oe_o}, {7'b0, VEC[i].oe});
                if (VEC[i].oe) check_val(int'(VEC[i].req), "ry_level", {7'b0, ry_by_o}, 8'h00);
            end
            if (VEC[i].rd && !VEC[i].arr) tg = ~tg;
        end
        @(negedge clk);
        apply('0);

        // R1: reset in the middle of a program returns to read, toggles cleared.
        op_start = 1'b1; op_code = 3'd1; op_poll = 1'b0;
        @(negedge clk);
        op_start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd_block = 3'd2;
        #1;
        check_val(1, "dq after reset", dq_o, array_data);   // R1
        check_val(1, "ry_oe after reset", {7'b0, ry_by_oe_o}, 8'h00); // R1
        @(negedge clk);
        op_start = 1'b1; op_code = 3'd1; op_poll = 1'b0;
        @(negedge clk);
        op_start = 1'b0; rd_stb = 1'b1;
        #1;
        check_val(1, "toggle cleared by reset", dq_o, 8'h80); // R1
        @(negedge clk);
        #1;
        check_val(11, "back-to-back read differs", dq_o, 8'hC0); // R11
        rd_stb = 1'b0;
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        #1;
        check_val(12, "read mode after done", dq_o, array_data); // R12

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule